// File: doc/BRIEF.md
# Memory-mapped scratch and LED mask register slave

This block is an AXI4-Lite slave with two registers. A 32-bit scratch word can be written and read back. Its readback comes out with the byte order reversed, so software can tell that the bus lanes are wired correctly. A 16-bit read-only status word always carries the low half of the scratch word, unswapped. That status word is ANDed bit by bit with a 16-bit switch input. The result drives a registered 16-bit LED output. A switch pattern therefore chooses which status bits appear on the LEDs.

The slave accepts one read and one write at a time. It captures write address and write data independently, and holds each response until the master takes it. Every access completes with an OKAY response, including accesses to addresses that hold no register.

Top module: `axil_led_regs`

## Requirements
- R1: After reset the scratch word is zero, `led_o` is zero, and no read or write response is pending.
- R2: A write of byte address 0x500 stores the full 32-bit word. A read of 0x500 returns the stored word with its bytes reversed: stored bits 7:0 on read bits 31:24, 15:8 on 23:16, 23:16 on 15:8, and 31:24 on 7:0.
- R3: A read of byte address 0x504 returns stored scratch bits 15:0, unswapped, in read bits 15:0, with read bits 31:16 zero.
- R4: A write to 0x504 completes with response 2'b00 and leaves the scratch word and the 0x504 readback unchanged.
- R5: A read of any address other than 0x500 or 0x504 returns 0x00000000 with response 2'b00. A write to such an address completes with response 2'b00 and changes nothing.
- R6: Write address and write data may arrive together, address first or data first. Exactly one write response follows. It is raised in the cycle in which the second of the two is accepted, and none is raised before that.
- R7: While a write response is pending, `s_bvalid_o` and `s_bresp_o` hold and both write-side readies are low. While read data is pending, `s_rvalid_o` and `s_rdata_o` hold and `s_arready_o` is low. Each ends on the clock edge on which the matching ready is high.
- R8: `led_o` equals scratch bits 15:0 ANDed bit by bit with `sw_i`. For example, a switch value of 0x00FF passes only the low 8 bits.
- R9: `led_o` is registered. It changes on the clock edge after the edge that updates the scratch word. After a change on `sw_i`, it changes on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| s_awaddr_i | input | 12 | Write address |
| s_awvalid_i | input | 1 | Write address valid |
| s_awready_o | output | 1 | Write address ready |
| s_wdata_i | input | 32 | Write data |
| s_wvalid_i | input | 1 | Write data valid |
| s_wready_o | output | 1 | Write data ready |
| s_bresp_o | output | 2 | Write response, always OKAY |
| s_bvalid_o | output | 1 | Write response valid |
| s_bready_i | input | 1 | Write response ready |
| s_araddr_i | input | 12 | Read address |
| s_arvalid_i | input | 1 | Read address valid |
| s_arready_o | output | 1 | Read address ready |
| s_rdata_o | output | 32 | Read data |
| s_rresp_o | output | 2 | Read response, always OKAY |
| s_rvalid_o | output | 1 | Read data valid |
| s_rready_i | input | 1 | Read data ready |
| sw_i | input | 16 | Per-bit LED enable switches |
| led_o | output | 16 | Masked status bits |

## Verification
The hardest case is a write whose address and data arrive in separate cycles. The first item must be parked while the slave has no response pending yet. The bench repeats each register write in all three arrival orders. After the first item is accepted it checks that no response is pending and that the matching ready has dropped. It also holds back the response and read-data readies for extra cycles to check that both stay stable. The switch input sweeps walking-one patterns plus the zero, all-ones and low-byte masks against several scratch values, and the bench compares `led_o` with the masked value it computes itself.

// File: rtl/axil_led_pkg.sv
package axil_led_pkg;
  localparam logic [1:0] RESP_OKAY = 2'b00;

  typedef enum logic [1:0] {
    SEL_NONE    = 2'd0,
    SEL_SCRATCH = 2'd1,
    SEL_STATUS  = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/axil_led_wr_ctrl.sv
module axil_led_wr_ctrl #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] awaddr_i,
  input  logic              awvalid_i,
  output logic              awready_o,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wvalid_i,
  output logic              wready_o,
  output logic              bvalid_o,
  input  logic              bready_i,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [DATA_W-1:0] wdata_o
);
  logic              aw_held_q, w_held_q, bvalid_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              aw_fire, w_fire;

  assign awready_o = ~aw_held_q & ~bvalid_q;
  assign wready_o  = ~w_held_q & ~bvalid_q;
  assign aw_fire   = awvalid_i & awready_o;
  assign w_fire    = wvalid_i & wready_o;
  // commit once both halves are either parked or arriving now
  assign we_o      = (aw_held_q | aw_fire) & (w_held_q | w_fire);
  assign waddr_o   = aw_held_q ? addr_q : awaddr_i;
  assign wdata_o   = w_held_q ? data_q : wdata_i;
  assign bvalid_o  = bvalid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aw_held_q <= 1'b0;
      w_held_q  <= 1'b0;
      bvalid_q  <= 1'b0;
      addr_q    <= '0;
      data_q    <= '0;
    end else begin
      if (aw_fire) addr_q <= awaddr_i;
      if (w_fire)  data_q <= wdata_i;
      if (we_o) begin
        aw_held_q <= 1'b0;
        w_held_q  <= 1'b0;
        bvalid_q  <= 1'b1;
      end else begin
        if (aw_fire) aw_held_q <= 1'b1;
        if (w_fire)  w_held_q  <= 1'b1;
        if (bvalid_q && bready_i) bvalid_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/axil_led_rd_ctrl.sv
module axil_led_rd_ctrl #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arvalid_i,
  output logic              arready_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  input  logic              rready_i
);
  logic              rvalid_q;
  logic [DATA_W-1:0] rdata_q;

  assign arready_o = ~rvalid_q;
  assign rvalid_o  = rvalid_q;
  assign rdata_o   = rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else if (arvalid_i && arready_o) begin
      rvalid_q <= 1'b1;
      rdata_q  <= rd_data_i;
    end else if (rvalid_q && rready_i) begin
      rvalid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/axil_led_regfile.sv
module axil_led_regfile
  import axil_led_pkg::*;
#(
  parameter int                ADDR_W      = 12,
  parameter int                DATA_W      = 32,
  parameter int                LED_W       = 16,
  parameter logic [ADDR_W-1:0] SCRATCH_OFS = 12'h500,
  parameter logic [ADDR_W-1:0] STATUS_OFS  = 12'h504
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [LED_W-1:0]  sw_i,
  output logic [LED_W-1:0]  led_o
);
  localparam int NBYTES = DATA_W / 8;

  logic [DATA_W-1:0] scratch_q;
  logic [DATA_W-1:0] scratch_rev;
  logic [LED_W-1:0]  status;
  logic [LED_W-1:0]  led_q;
  reg_sel_e          rsel;

  for (genvar b = 0; b < NBYTES; b++) begin : g_rev
    assign scratch_rev[8*b +: 8] = scratch_q[8*(NBYTES-1-b) +: 8];
  end

  assign status = scratch_q[LED_W-1:0];

  always_comb begin
    if (raddr_i == SCRATCH_OFS)     rsel = SEL_SCRATCH;
    else if (raddr_i == STATUS_OFS) rsel = SEL_STATUS;
    else                            rsel = SEL_NONE;
  end

  always_comb begin
    unique case (rsel)
      SEL_SCRATCH: rd_data_o = scratch_rev;
      SEL_STATUS:  rd_data_o = {{(DATA_W-LED_W){1'b0}}, status};
      default:     rd_data_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scratch_q <= '0;
      led_q     <= '0;
    end else begin
      if (we_i && waddr_i == SCRATCH_OFS) scratch_q <= wdata_i;
      led_q <= status & sw_i;
    end
  end

  assign led_o = led_q;
endmodule

// File: rtl/axil_led_regs.sv
module axil_led_regs
  import axil_led_pkg::*;
#(
  parameter int                ADDR_W      = 12,
  parameter int                DATA_W      = 32,
  parameter int                LED_W       = 16,
  parameter logic [ADDR_W-1:0] SCRATCH_OFS = 12'h500,
  parameter logic [ADDR_W-1:0] STATUS_OFS  = 12'h504
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] s_awaddr_i,
  input  logic              s_awvalid_i,
  output logic              s_awready_o,
  input  logic [DATA_W-1:0] s_wdata_i,
  input  logic              s_wvalid_i,
  output logic              s_wready_o,
  output logic [1:0]        s_bresp_o,
  output logic              s_bvalid_o,
  input  logic              s_bready_i,
  input  logic [ADDR_W-1:0] s_araddr_i,
  input  logic              s_arvalid_i,
  output logic              s_arready_o,
  output logic [DATA_W-1:0] s_rdata_o,
  output logic [1:0]        s_rresp_o,
  output logic              s_rvalid_o,
  input  logic              s_rready_i,
  input  logic [LED_W-1:0]  sw_i,
  output logic [LED_W-1:0]  led_o
);
  logic              we;
  logic [ADDR_W-1:0] waddr;
  logic [DATA_W-1:0] wdata;
  logic [DATA_W-1:0] rd_data;

  axil_led_wr_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_wr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .awaddr_i  (s_awaddr_i),
    .awvalid_i (s_awvalid_i),
    .awready_o (s_awready_o),
    .wdata_i   (s_wdata_i),
    .wvalid_i  (s_wvalid_i),
    .wready_o  (s_wready_o),
    .bvalid_o  (s_bvalid_o),
    .bready_i  (s_bready_i),
    .we_o      (we),
    .waddr_o   (waddr),
    .wdata_o   (wdata)
  );

  axil_led_rd_ctrl #(.DATA_W(DATA_W)) i_rd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .arvalid_i (s_arvalid_i),
    .arready_o (s_arready_o),
    .rd_data_i (rd_data),
    .rdata_o   (s_rdata_o),
    .rvalid_o  (s_rvalid_o),
    .rready_i  (s_rready_i)
  );

  axil_led_regfile #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LED_W(LED_W),
    .SCRATCH_OFS(SCRATCH_OFS), .STATUS_OFS(STATUS_OFS)
  ) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (we),
    .waddr_i   (waddr),
    .wdata_i   (wdata),
    .raddr_i   (s_araddr_i),
    .rd_data_o (rd_data),
    .sw_i      (sw_i),
    .led_o     (led_o)
  );

  assign s_bresp_o = RESP_OKAY;
  assign s_rresp_o = RESP_OKAY;
endmodule

// File: rtl/axil_led_regs_chk.sv
module axil_led_regs_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int LED_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              s_awready_o,
  input logic              s_wready_o,
  input logic [1:0]        s_bresp_o,
  input logic              s_bvalid_o,
  input logic              s_bready_i,
  input logic              s_arready_o,
  input logic [DATA_W-1:0] s_rdata_o,
  input logic [1:0]        s_rresp_o,
  input logic              s_rvalid_o,
  input logic              s_rready_i,
  input logic [LED_W-1:0]  sw_i,
  input logic [LED_W-1:0]  led_o
);
  a_r7_b_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_bvalid_o && !s_bready_i |=> s_bvalid_o && $stable(s_bresp_o));

  a_r7_r_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_rvalid_o && !s_rready_i |=> s_rvalid_o && $stable(s_rdata_o));

  a_r7_one_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_bvalid_o |-> !s_awready_o && !s_wready_o);

  a_r7_one_rd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_rvalid_o |-> !s_arready_o);

  a_r5_okay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_bvalid_o |-> s_bresp_o == 2'b00) and (s_rvalid_o |-> s_rresp_o == 2'b00));

  // R8: no LED lit where the switch was off on the previous edge
  a_r8_led_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) or ((led_o & ~$past(sw_i)) == '0));
endmodule

bind axil_led_regs axil_led_regs_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LED_W(LED_W)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .s_awready_o (s_awready_o),
  .s_wready_o  (s_wready_o),
  .s_bresp_o   (s_bresp_o),
  .s_bvalid_o  (s_bvalid_o),
  .s_bready_i  (s_bready_i),
  .s_arready_o (s_arready_o),
  .s_rdata_o   (s_rdata_o),
  .s_rresp_o   (s_rresp_o),
  .s_rvalid_o  (s_rvalid_o),
  .s_rready_i  (s_rready_i),
  .sw_i        (sw_i),
  .led_o       (led_o)
);

// File: tb/test_axil_led_regs.sv
`timescale 1ns/1ps
module test_axil_led_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] awaddr = '0, araddr = '0;
  logic        awvalid = 1'b0, wvalid = 1'b0, bready = 1'b0, arvalid = 1'b0, rready = 1'b0;
  logic [31:0] wdata = '0;
  logic [15:0] sw = '0;
  logic        awready, wready, bvalid, arready, rvalid;
  logic [1:0]  bresp, rresp;
  logic [31:0] rdata;
  logic [15:0] led;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [15:0] led_at_b;

  always #2.5 clk = ~clk;

  axil_led_regs i_axil_led_regs (
    .clk_i(clk), .rst_ni(rst_n),
    .s_awaddr_i(awaddr), .s_awvalid_i(awvalid), .s_awready_o(awready),
    .s_wdata_i(wdata), .s_wvalid_i(wvalid), .s_wready_o(wready),
    .s_bresp_o(bresp), .s_bvalid_o(bvalid), .s_bready_i(bready),
    .s_araddr_i(araddr), .s_arvalid_i(arvalid), .s_arready_o(arready),
    .s_rdata_o(rdata), .s_rresp_o(rresp), .s_rvalid_o(rvalid), .s_rready_i(rready),
    .sw_i(sw), .led_o(led)
  );

  function automatic logic [31:0] rev(input logic [31:0] x);
    return {x[7:0], x[15:8], x[23:16], x[31:24]};
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // order: 0 together, 1 address first, 2 data first
  task automatic axi_wr(input logic [11:0] a, input logic [31:0] d, input int order);
    @(negedge clk);
    if (order != 2) begin awaddr = a; awvalid = 1'b1; end
    if (order != 1) begin wdata = d; wvalid = 1'b1; end
    @(posedge clk); @(negedge clk);
    if (order == 1) begin
      awvalid = 1'b0;
      chk(!bvalid && !awready, "R6 early", {30'd0, bvalid, awready}, 32'd0);
      wdata = d; wvalid = 1'b1;
      @(posedge clk); @(negedge clk);
      wvalid = 1'b0;
    end else if (order == 2) begin
      wvalid = 1'b0;
      chk(!bvalid && !wready, "R6 early", {30'd0, bvalid, wready}, 32'd0);
      awaddr = a; awvalid = 1'b1;
      @(posedge clk); @(negedge clk);
      awvalid = 1'b0;
    end else begin
      awvalid = 1'b0; wvalid = 1'b0;
    end
    led_at_b = led;
    chk(bvalid && bresp == 2'b00, "R6 resp", {29'd0, bvalid, bresp}, 32'h4);
    repeat (2) @(negedge clk);
    chk(bvalid && !awready && !wready, "R7 b hold", {29'd0, bvalid, awready, wready}, 32'h4);
    bready = 1'b1;
    @(posedge clk); @(negedge clk);
    bready = 1'b0;
    chk(!bvalid, "R6 single", {31'd0, bvalid}, 32'd0);
  endtask

  task automatic axi_rd(input logic [11:0] a, output logic [31:0] d);
    logic [31:0] first;
    @(negedge clk);
    araddr = a; arvalid = 1'b1;
    @(posedge clk); @(negedge clk);
    arvalid = 1'b0;
    first = rdata;
    chk(rvalid && rresp == 2'b00, "R7 r valid", {29'd0, rvalid, rresp}, 32'h4);
    @(negedge clk);
    chk(rvalid && !arready && rdata == first, "R7 r hold", rdata, first);
    d = rdata;
    rready = 1'b1;
    @(posedge clk); @(negedge clk);
    rready = 1'b0;
    chk(!rvalid, "R7 r done", {31'd0, rvalid}, 32'd0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected<100000", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] pats[6];
    logic [15:0] sws[19];
    pats = '{32'h0, 32'hFFFF_FFFF, 32'h1234_5678, 32'hA5C3_0F96, 32'h8000_0001, 32'h00FF_FF00};
    for (int i = 0; i < 16; i++) sws[i] = 16'h1 << i;
    sws[16] = 16'h0000; sws[17] = 16'hFFFF; sws[18] = 16'h00FF;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(led == 16'h0 && !bvalid && !rvalid, "R1", {15'd0, bvalid, led}, 32'd0);
    axi_rd(12'h500, rd);
    chk(rd == 32'h0, "R1 scratch", rd, 32'h0);

    // R9: scratch change reaches LEDs one edge later
    @(negedge clk); sw = 16'hFFFF;
    axi_wr(12'h500, 32'h0000_BEEF, 0);
    chk(led_at_b == 16'h0, "R9 write lag", {16'd0, led_at_b}, 32'h0);
    chk(led == 16'hBEEF, "R9 write", {16'd0, led}, 32'hBEEF);
    @(negedge clk); sw = 16'h00FF;
    chk(led == 16'hBEEF, "R9 sw lag", {16'd0, led}, 32'hBEEF);
    @(negedge clk);
    chk(led == 16'h00EF, "R9 sw", {16'd0, led}, 32'h00EF);

    // R2 R3 R8: patterns x orders x switch sweep
    for (int p = 0; p < 6; p++) begin
      axi_wr(12'h500, pats[p], p % 3);
      axi_rd(12'h500, rd);
      chk(rd == rev(pats[p]), "R2", rd, rev(pats[p]));
      axi_rd(12'h504, rd);
      chk(rd == {16'd0, pats[p][15:0]}, "R3", rd, {16'd0, pats[p][15:0]});
      for (int s = 0; s < 19; s++) begin
        @(negedge clk); sw = sws[s];
        @(negedge clk);
        chk(led == (pats[p][15:0] & sws[s]), "R8", {16'd0, led}, {16'd0, pats[p][15:0] & sws[s]});
      end
    end

    // R2 walking one over every bit, all orders
    for (int b = 0; b < 32; b++) begin
      axi_wr(12'h500, 32'h1 << b, b % 3);
      axi_rd(12'h500, rd);
      chk(rd == rev(32'h1 << b), "R2 walk", rd, rev(32'h1 << b));
    end

    // R4: status register write is ignored
    axi_wr(12'h500, 32'hCAFE_1357, 0);
    @(negedge clk); sw = 16'hFFFF;
    for (int o = 0; o < 3; o++) begin
      axi_wr(12'h504, 32'h0000_9999, o);
      axi_rd(12'h504, rd);
      chk(rd == 32'h0000_1357, "R4 status", rd, 32'h0000_1357);
      axi_rd(12'h500, rd);
      chk(rd == rev(32'hCAFE_1357), "R4 scratch", rd, rev(32'hCAFE_1357));
      chk(led == 16'h1357, "R4 led", {16'd0, led}, 32'h1357);
    end

    // R5: unmapped addresses
    for (int k = 0; k < 6; k++) begin
      logic [11:0] ua;
      ua = (k == 0) ? 12'h000 : (k == 1) ? 12'h4FC : (k == 2) ? 12'h501 :
           (k == 3) ? 12'h508 : (k == 4) ? 12'hD00 : 12'hFFF;
      axi_wr(ua, 32'hDEAD_0000 | k, k % 3);
      axi_rd(ua, rd);
      chk(rd == 32'h0, "R5 read", rd, 32'h0);
      axi_rd(12'h500, rd);
      chk(rd == rev(32'hCAFE_1357), "R5 no write", rd, rev(32'hCAFE_1357));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule